// File: doc/BRIEF.md
# Maintenance Request Local Responder

This block answers configuration maintenance requests aimed at the switch itself. An upstream parser hands it one decoded request at a time: transaction code, size code, transaction tag, hop count, a 21-bit double-word offset, a word-select bit, the two device IDs and one 64-bit data double-word. Only a request with a hop count of zero, a 4-byte size code and a read or write code is served. Every other request is discarded without any side effect.

A served request becomes exactly one 32-bit access on a simple register bus. The bus has a strobe, a write enable, a byte address, write data, read data and an acknowledge. The word-select bit chooses which half of the 64-bit double-word carries the 32-bit value. Once the access is acknowledged, the block presents a one-cycle response. The response has its header already filled in. For a read it also carries the register value, placed back into the correct half of a double-word.

The responder holds one request at a time. It lowers its ready signal from the moment it accepts a request until its response cycle is over.

Top module: `mrr_responder`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, `bus_stb` is 0 and `rsp_valid` is 0.
- R2: A request is served locally when it is accepted (`req_valid` and `req_ready` high at a clock edge) with transaction code 0, size code 4'b1000 and hop count 0. From the next cycle, `bus_stb` is high with `bus_we` = 0 and `bus_addr` = {offset, word-select, 2'b00}. A request with code 1 and the same size and hop count is served the same way, with `bus_we` = 1.
- R3: For a write, `bus_wdata` is bits 63:32 of the request data when word-select is 0, and bits 31:0 when word-select is 1.
- R4: `bus_stb`, `bus_we`, `bus_addr` and `bus_wdata` hold steady until the first cycle in which `bus_ack` is high. The strobe drops after that cycle, and `rsp_valid` is high for exactly the following cycle.
- R5: A read response has code 2 (`rsp_ttype` = 4'd2) and `rsp_has_data` = 1. Its `rsp_data` holds the acknowledged `bus_rdata` in bits 63:32 when the request's word-select was 0, or in bits 31:0 when it was 1. The other half is zero.
- R6: A write response has code 3 (`rsp_ttype` = 4'd3), `rsp_has_data` = 0 and `rsp_data` = 0.
- R7: Every response echoes the request's transaction tag. It carries hop count 8'hFF, size code 0, offset 0 and word-select 0.
- R8: The response source ID is the request's destination ID, and the response destination ID is the request's source ID.
- R9: An accepted request with a non-zero hop count causes no bus access and no response, and `req_ready` stays 1.
- R10: An accepted request with a transaction code other than 0 or 1, or a size code other than 4'b1000, causes no bus access and no response.
- R11: `req_ready` is 0 from the cycle after a request is served until the end of its response cycle. A request presented in that window is neither accepted nor remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request fields are valid |
| req_ready | output | 1 | Responder can take a request |
| req_ttype | input | 4 | Transaction code |
| req_size | input | 4 | Size code |
| req_tid | input | 8 | Transaction tag |
| req_hop | input | 8 | Hop count |
| req_offset | input | 21 | Double-word offset |
| req_wdptr | input | 1 | Word-select within the double-word |
| req_src_id | input | 16 | Requester device ID |
| req_dst_id | input | 16 | Target device ID |
| req_data | input | 64 | Write data double-word |
| bus_stb | output | 1 | Register bus strobe |
| bus_we | output | 1 | Register bus write enable |
| bus_addr | output | 24 | Register byte address |
| bus_wdata | output | 32 | Register write data |
| bus_rdata | input | 32 | Register read data |
| bus_ack | input | 1 | Register bus acknowledge |
| rsp_valid | output | 1 | Response fields valid for one cycle |
| rsp_ttype | output | 4 | Response transaction code |
| rsp_size | output | 4 | Response size code |
| rsp_tid | output | 8 | Echoed transaction tag |
| rsp_hop | output | 8 | Response hop count |
| rsp_offset | output | 21 | Response offset |
| rsp_wdptr | output | 1 | Response word-select |
| rsp_src_id | output | 16 | Response source ID |
| rsp_dst_id | output | 16 | Response destination ID |
| rsp_has_data | output | 1 | Response carries a data double-word |
| rsp_data | output | 64 | Response data double-word |

## Verification
Two events can fall in the same cycle: the one-cycle response, and the arrival of the next request. The bench provokes this by holding `req_valid` high with a fresh request across a whole transaction, so the request is present during the response cycle. A behavioural model then judges the outcome every cycle. The held request must be refused during the response cycle and taken on the edge that follows it. The bench also sets the acknowledge latency to zero, which makes the acknowledge arrive in the very first strobe cycle.

// File: rtl/mrr_pkg.sv
// Shared codes for the maintenance request responder.
// Assumes transaction and size codes are 4 bits wide.
package mrr_pkg;
    typedef enum logic [3:0] {
        TT_RD_REQ = 4'd0,
        TT_WR_REQ = 4'd1,
        TT_RD_RSP = 4'd2,
        TT_WR_RSP = 4'd3
    } mnt_ttype_e;

    localparam logic [3:0] SIZE_ONE_WORD = 4'b1000;
    localparam logic [3:0] SIZE_RESPONSE = 4'b0000;
endpackage

// File: rtl/mrr_classify.sv
// Decides whether a request is served locally and whether it reads or writes.
// Assumes the fields are stable while they are being judged; purely combinational.
module mrr_classify #(
    parameter int HOP_W = 8
) (
    input  logic [3:0]       ttype,
    input  logic [3:0]       size,
    input  logic [HOP_W-1:0] hop,
    output logic             local_rd,
    output logic             local_wr
);
    import mrr_pkg::*;

    logic here;

    // A request is local only at hop zero with a single-word size.
    always_comb begin
        here     = (hop == '0) && (size == SIZE_ONE_WORD);
        local_rd = here && (ttype == TT_RD_REQ);
        local_wr = here && (ttype == TT_WR_REQ);
    end
endmodule

// File: rtl/mrr_bus_master.sv
// Runs one register bus access: raises the strobe on start and holds the
// address, direction and data until acknowledge. Assumes start only when idle.
module mrr_bus_master #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_we,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [WORD_W-1:0] start_wdata,
    input  logic              bus_ack,
    output logic              bus_stb,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic              done
);
    // Capture the access at start, release the strobe on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_stb   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else if (start) begin
            bus_stb   <= 1'b1;
            bus_we    <= start_we;
            bus_addr  <= start_addr;
            bus_wdata <= start_wdata;
        end else if (bus_stb && bus_ack) begin
            bus_stb   <= 1'b0;
        end
    end

    assign done = bus_stb && bus_ack;
endmodule

// File: rtl/mrr_reply_gen.sv
// Remembers the request context and emits a one-cycle response after the
// bus access completes. Assumes capture and done never coincide.
module mrr_reply_gen #(
    parameter int WORD_W   = 32,
    parameter int ID_W     = 16,
    parameter int TID_W    = 8,
    parameter int HOP_W    = 8,
    parameter int OFFSET_W = 21,
    localparam int DW_W    = 2 * WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic                cap_read,
    input  logic                cap_wp,
    input  logic [TID_W-1:0]    cap_tid,
    input  logic [ID_W-1:0]     cap_src,
    input  logic [ID_W-1:0]     cap_dst,
    input  logic                done,
    input  logic [WORD_W-1:0]   rdata,
    output logic                rsp_valid,
    output logic [3:0]          rsp_ttype,
    output logic [3:0]          rsp_size,
    output logic [TID_W-1:0]    rsp_tid,
    output logic [HOP_W-1:0]    rsp_hop,
    output logic [OFFSET_W-1:0] rsp_offset,
    output logic                rsp_wdptr,
    output logic [ID_W-1:0]     rsp_src_id,
    output logic [ID_W-1:0]     rsp_dst_id,
    output logic                rsp_has_data,
    output logic [DW_W-1:0]     rsp_data
);
    import mrr_pkg::*;

    logic              rd_q;
    logic              wp_q;
    logic [TID_W-1:0]  tid_q;
    logic [ID_W-1:0]   src_q;
    logic [ID_W-1:0]   dst_q;
    logic [DW_W-1:0]   data_q;
    logic              valid_q;
    logic [DW_W-1:0]   placed;

    // Place the read word into the half chosen by the word-select bit.
    always_comb begin
        if (wp_q) placed = {{WORD_W{1'b0}}, rdata};
        else      placed = {rdata, {WORD_W{1'b0}}};
    end

    // Hold the request context while the bus access is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= 1'b0;
            wp_q  <= 1'b0;
            tid_q <= '0;
            src_q <= '0;
            dst_q <= '0;
        end else if (capture) begin
            rd_q  <= cap_read;
            wp_q  <= cap_wp;
            tid_q <= cap_tid;
            src_q <= cap_src;
            dst_q <= cap_dst;
        end
    end

    // Latch response data on completion and pulse the valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= done;
            if (done) data_q <= rd_q ? placed : '0;
        end
    end

    assign rsp_valid    = valid_q;
    assign rsp_ttype    = rd_q ? TT_RD_RSP : TT_WR_RSP;
    assign rsp_size     = SIZE_RESPONSE;
    assign rsp_tid      = tid_q;
    assign rsp_hop      = '1;
    assign rsp_offset   = '0;
    assign rsp_wdptr    = 1'b0;
    assign rsp_src_id   = dst_q;
    assign rsp_dst_id   = src_q;
    assign rsp_has_data = rd_q;
    assign rsp_data     = data_q;
endmodule

// File: rtl/mrr_responder.sv
// Top of the maintenance request responder: filters requests, drives one
// register bus access per served request and produces the response.
// Assumes one request in flight; upstream waits on req_ready.
module mrr_responder #(
    parameter int OFFSET_W = 21,
    parameter int WORD_W   = 32,
    parameter int ID_W     = 16,
    parameter int TID_W    = 8,
    parameter int HOP_W    = 8,
    localparam int DW_W    = 2 * WORD_W,
    localparam int ADDR_W  = OFFSET_W + 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [3:0]          req_ttype,
    input  logic [3:0]          req_size,
    input  logic [TID_W-1:0]    req_tid,
    input  logic [HOP_W-1:0]    req_hop,
    input  logic [OFFSET_W-1:0] req_offset,
    input  logic                req_wdptr,
    input  logic [ID_W-1:0]     req_src_id,
    input  logic [ID_W-1:0]     req_dst_id,
    input  logic [DW_W-1:0]     req_data,
    output logic                bus_stb,
    output logic                bus_we,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [WORD_W-1:0]   bus_wdata,
    input  logic [WORD_W-1:0]   bus_rdata,
    input  logic                bus_ack,
    output logic                rsp_valid,
    output logic [3:0]          rsp_ttype,
    output logic [3:0]          rsp_size,
    output logic [TID_W-1:0]    rsp_tid,
    output logic [HOP_W-1:0]    rsp_hop,
    output logic [OFFSET_W-1:0] rsp_offset,
    output logic                rsp_wdptr,
    output logic [ID_W-1:0]     rsp_src_id,
    output logic [ID_W-1:0]     rsp_dst_id,
    output logic                rsp_has_data,
    output logic [DW_W-1:0]     rsp_data
);
    logic              is_rd;
    logic              is_wr;
    logic              start;
    logic              done;
    logic [ADDR_W-1:0] acc_addr;
    logic [WORD_W-1:0] acc_wdata;

    mrr_classify #(.HOP_W(HOP_W)) u_classify (
        .ttype    (req_ttype),
        .size     (req_size),
        .hop      (req_hop),
        .local_rd (is_rd),
        .local_wr (is_wr)
    );

    // Busy from acceptance until the response cycle has passed.
    assign req_ready = !bus_stb && !rsp_valid;
    assign start     = req_valid && req_ready && (is_rd || is_wr);

    // Byte address and the selected 32-bit half of the write double-word.
    always_comb begin
        acc_addr  = {req_offset, req_wdptr, 2'b00};
        acc_wdata = req_wdptr ? req_data[WORD_W-1:0] : req_data[DW_W-1:WORD_W];
    end

    mrr_bus_master #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_we    (is_wr),
        .start_addr  (acc_addr),
        .start_wdata (acc_wdata),
        .bus_ack     (bus_ack),
        .bus_stb     (bus_stb),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .done        (done)
    );

    mrr_reply_gen #(
        .WORD_W(WORD_W), .ID_W(ID_W), .TID_W(TID_W),
        .HOP_W(HOP_W), .OFFSET_W(OFFSET_W)
    ) u_reply (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture      (start),
        .cap_read     (is_rd),
        .cap_wp       (req_wdptr),
        .cap_tid      (req_tid),
        .cap_src      (req_src_id),
        .cap_dst      (req_dst_id),
        .done         (done),
        .rdata        (bus_rdata),
        .rsp_valid    (rsp_valid),
        .rsp_ttype    (rsp_ttype),
        .rsp_size     (rsp_size),
        .rsp_tid      (rsp_tid),
        .rsp_hop      (rsp_hop),
        .rsp_offset   (rsp_offset),
        .rsp_wdptr    (rsp_wdptr),
        .rsp_src_id   (rsp_src_id),
        .rsp_dst_id   (rsp_dst_id),
        .rsp_has_data (rsp_has_data),
        .rsp_data     (rsp_data)
    );
endmodule

// File: rtl/mrr_responder_chk.sv
// Protocol checker for the responder, attached to every instance by bind.
// Assumes it observes the top-level ports only.
module mrr_responder_chk #(
    parameter int OFFSET_W = 21,
    parameter int WORD_W   = 32,
    parameter int HOP_W    = 8,
    localparam int DW_W    = 2 * WORD_W,
    localparam int ADDR_W  = OFFSET_W + 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic [3:0]          req_ttype,
    input logic [3:0]          req_size,
    input logic [HOP_W-1:0]    req_hop,
    input logic                bus_stb,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [WORD_W-1:0]   bus_wdata,
    input logic                bus_ack,
    input logic                rsp_valid,
    input logic [3:0]          rsp_ttype,
    input logic [3:0]          rsp_size,
    input logic [HOP_W-1:0]    rsp_hop,
    input logic [OFFSET_W-1:0] rsp_offset,
    input logic                rsp_wdptr,
    input logic                rsp_has_data,
    input logic [DW_W-1:0]     rsp_data
);
    // R2
    rd_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_ttype == 4'd0 && req_size == 4'b1000 && req_hop == '0
        |=> bus_stb && !bus_we);

    // R4
    stb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stb && !bus_ack
        |=> bus_stb && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    // R4
    rsp_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stb && bus_ack |=> rsp_valid && !bus_stb);

    // R4
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6
    wr_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ttype == 4'd3 |-> !rsp_has_data && rsp_data == '0);

    // R7
    rsp_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_hop == {HOP_W{1'b1}} && rsp_offset == '0 && !rsp_wdptr && rsp_size == 4'd0);

    // R9
    hop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_hop != '0 |=> !bus_stb);

    // R11
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb || rsp_valid) |-> !req_ready);
endmodule

bind mrr_responder mrr_responder_chk #(
    .OFFSET_W(OFFSET_W), .WORD_W(WORD_W), .HOP_W(HOP_W)
) u_chk (.*);

// File: tb/mrr_responder_bench.sv
// Bench: behavioural reference model compared against the ports every cycle.
module mrr_responder_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_ttype = '0;
    logic [3:0]  req_size = '0;
    logic [7:0]  req_tid = '0;
    logic [7:0]  req_hop = '0;
    logic [20:0] req_offset = '0;
    logic        req_wdptr = 1'b0;
    logic [15:0] req_src_id = '0;
    logic [15:0] req_dst_id = '0;
    logic [63:0] req_data = '0;
    logic        bus_stb;
    logic        bus_we;
    logic [23:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;
    logic        rsp_valid;
    logic [3:0]  rsp_ttype;
    logic [3:0]  rsp_size;
    logic [7:0]  rsp_tid;
    logic [7:0]  rsp_hop;
    logic [20:0] rsp_offset;
    logic        rsp_wdptr;
    logic [15:0] rsp_src_id;
    logic [15:0] rsp_dst_id;
    logic        rsp_has_data;
    logic [63:0] rsp_data;

    int n_cmp = 0;
    int n_bad = 0;
    int ack_lat = 0;
    int ack_cnt = 0;

    // reference model state: 0 idle, 1 bus access, 2 response
    int          m_phase = 0;
    logic        m_we;
    logic [23:0] m_addr;
    logic [31:0] m_wdata;
    logic [7:0]  m_tid;
    logic [15:0] m_src;
    logic [15:0] m_dst;
    logic        m_wp;
    logic [31:0] m_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    mrr_responder u_mrr_responder (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    task automatic model_advance();
        if (!rst_n) m_phase = 0;
        else case (m_phase)
            0: if (req_valid && req_hop == 8'd0 && req_size == 4'b1000 &&
                   (req_ttype == 4'd0 || req_ttype == 4'd1)) begin
                m_phase = 1;
                m_we    = (req_ttype == 4'd1);
                m_addr  = 24'(req_offset) * 24'd8 + (req_wdptr ? 24'd4 : 24'd0);
                m_wdata = req_wdptr ? req_data[31:0] : req_data[63:32];
                m_tid   = req_tid;
                m_src   = req_src_id;
                m_dst   = req_dst_id;
                m_wp    = req_wdptr;
            end
            1: if (bus_ack) begin m_phase = 2; m_rdata = bus_rdata; end
            default: m_phase = 0;
        endcase
    endtask

    task automatic compare();
        check("R11 ready", 64'(req_ready), 64'(m_phase == 0));
        check("R2 strobe", 64'(bus_stb), 64'(m_phase == 1));
        if (m_phase == 1) begin
            check("R2 direction", 64'(bus_we), 64'(m_we));
            check("R2 address", 64'(bus_addr), 64'(m_addr));
            if (m_we) check("R3 write data", 64'(bus_wdata), 64'(m_wdata));
        end
        check("R4 response valid", 64'(rsp_valid), 64'(m_phase == 2));
        if (m_phase == 2) begin
            if (!m_we) begin
                check("R5 code", 64'(rsp_ttype), 64'd2);
                check("R5 has data", 64'(rsp_has_data), 64'd1);
                check("R5 data", rsp_data, m_wp ? {32'h0, m_rdata} : {m_rdata, 32'h0});
            end else begin
                check("R6 code", 64'(rsp_ttype), 64'd3);
                check("R6 has data", 64'(rsp_has_data), 64'd0);
                check("R6 data", rsp_data, 64'd0);
            end
            check("R7 tag", 64'(rsp_tid), 64'(m_tid));
            check("R7 hop", 64'(rsp_hop), 64'hFF);
            check("R7 size", 64'(rsp_size), 64'd0);
            check("R7 offset", 64'(rsp_offset), 64'd0);
            check("R7 wdptr", 64'(rsp_wdptr), 64'd0);
            check("R8 source", 64'(rsp_src_id), 64'(m_dst));
            check("R8 destination", 64'(rsp_dst_id), 64'(m_src));
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        model_advance();
        compare();
        if (bus_stb) begin
            bus_ack = (ack_cnt >= ack_lat);
            ack_cnt++;
        end else begin
            bus_ack = 1'b0;
            ack_cnt = 0;
        end
    endtask

    task automatic send(input logic [3:0] tt, input logic [3:0] sz, input logic [7:0] hop,
                        input logic [20:0] off, input logic wp, input logic [15:0] src,
                        input logic [15:0] dst, input logic [7:0] tid, input logic [63:0] data,
                        input int lat, input logic [31:0] rdata, input int hold);
        req_ttype = tt; req_size = sz; req_hop = hop; req_offset = off; req_wdptr = wp;
        req_src_id = src; req_dst_id = dst; req_tid = tid; req_data = data;
        ack_lat = lat; bus_rdata = rdata;
        req_valid = 1'b1;
        repeat (hold) step();
        req_valid = 1'b0;
        repeat (lat + 4) step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R4 watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) step();
        check("R1 ready in reset", 64'(req_ready), 64'd1);
        check("R1 strobe in reset", 64'(bus_stb), 64'd0);
        check("R1 response in reset", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        step();
        check("R1 ready after reset", 64'(req_ready), 64'd1);

        // R2 R5: reads, both halves, immediate and delayed acknowledge
        send(4'd0, 4'b1000, 8'd0, 21'h00000E, 1'b0, 16'h0002, 16'h0000, 8'h11,
             64'h0, 0, 32'hA5A5_1234, 1);
        send(4'd0, 4'b1000, 8'd0, 21'h1FFFFF, 1'b1, 16'h00C3, 16'h7001, 8'h42,
             64'h0, 3, 32'h89AB_CDEF, 1);

        // R3 R6: writes, both halves
        send(4'd1, 4'b1000, 8'd0, 21'h00002A, 1'b0, 16'h1234, 16'hFFFF, 8'hDE,
             64'h1122_3344_5566_7788, 1, 32'hFFFF_FFFF, 1);
        send(4'd1, 4'b1000, 8'd0, 21'h000000, 1'b1, 16'hBEEF, 16'h0001, 8'hAD,
             64'h1122_3344_5566_7788, 0, 32'h0, 1);

        // R9: non-zero hop count is dropped
        send(4'd0, 4'b1000, 8'd1, 21'h000010, 1'b0, 16'h0002, 16'h0000, 8'h05,
             64'h0, 0, 32'h1, 1);
        check("R9 no access or response", 64'(bus_stb | rsp_valid), 64'd0);
        check("R9 ready kept", 64'(req_ready), 64'd1);
        send(4'd1, 4'b1000, 8'hFF, 21'h000010, 1'b1, 16'h0002, 16'h0000, 8'h06,
             64'h1, 0, 32'h1, 1);
        check("R9 no access after write", 64'(bus_stb | rsp_valid), 64'd0);

        // R10: other codes and sizes are dropped
        for (int c = 2; c < 16; c += 3) begin
            send(4'(c), 4'b1000, 8'd0, 21'h000020, 1'b0, 16'h0003, 16'h0004, 8'(c),
                 64'h0, 0, 32'h2, 1);
            check("R10 code dropped", 64'(bus_stb | rsp_valid), 64'd0);
        end
        send(4'd0, 4'b0100, 8'd0, 21'h000020, 1'b0, 16'h0003, 16'h0004, 8'h77,
             64'h0, 0, 32'h2, 1);
        check("R10 size dropped", 64'(bus_stb | rsp_valid), 64'd0);

        // R11: a request held through the response cycle is taken only afterwards
        send(4'd0, 4'b1000, 8'd0, 21'h000033, 1'b1, 16'h0A0A, 16'h0B0B, 8'h99,
             64'h0, 2, 32'h0F0F_F0F0, 9);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule